// File: doc/BRIEF.md
# Quarter-Sample Luma Interpolator

This block produces the sixteen predicted luma samples of one 4x4 block at quarter-sample motion-vector precision. A 9x9 patch of reference pixels is written into it one row per cycle. The patch's top-left pixel sits two pixels up and two pixels left of the integer motion-vector position. A start strobe then supplies the two-bit fractional offsets of the horizontal and vertical motion-vector components. The block emits one predicted sample per cycle, in raster order, through a FIFO write port that stalls while the FIFO reports full.

All sixteen fractional positions are supported. Half-sample values come from the six-tap filter (1,-5,20,20,-5,1), rounded and clipped. The centre half-sample is filtered again over the unclipped vertical intermediates. Quarter-sample values are the rounded-up mean of the two nearest full- or half-sample values. Each block has its own motion vector, so a new patch and fraction are given for every block.

Top module: `qpel_luma_interp`

## Requirements
- R1: After reset `busy` and `out_wr` are low, and they stay low until a start is accepted.
- R2: A `start` seen while idle raises `busy` on the next cycle. Exactly 16 writes follow, in raster order: output index k is the pixel at column k mod 4 and row k div 4. `busy` falls in the cycle after the 16th write.
- R3: With both fractions 0, output pixel (x,y) equals patch pixel (row y+2, column x+2). Patch row r is written through `win_row`=r, and column c sits in `win_data[8c+7:8c]`.
- R4: With one fraction 2 and the other 0, the output is the six-tap half sample at that position, computed as clip((sum+16)>>5) to 0..255. The taps run along the row when the horizontal fraction is 2 and along the column when the vertical fraction is 2.
- R5: With both fractions 2, the output is clip((T+512)>>10). T is the six-tap filter applied across six unclipped vertical six-tap sums.
- R6: At every other position the output is (a+b+1)>>1 of the two nearest full or half samples. When both fractions are odd, these are the two diagonal half samples.
- R7: While `fifo_full` is high, `out_wr` is low and the pending pixel and its index are held.
- R8: While `busy`, a `start` or a patch write has no effect on the samples being produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_we | input | 1 | Patch row write enable |
| win_row | input | 4 | Patch row index, 0..8 |
| win_data | input | 72 | Nine 8-bit pixels of one patch row, column c at bits 8c+7:8c |
| start | input | 1 | Begin a block |
| frac_x | input | 2 | Horizontal quarter-sample offset |
| frac_y | input | 2 | Vertical quarter-sample offset |
| fifo_full | input | 1 | Output FIFO cannot accept a write |
| busy | output | 1 | Block in progress |
| out_wr | output | 1 | FIFO write strobe |
| out_pix | output | 8 | Predicted sample |

## Verification
The bench sweeps all sixteen fractional positions over several patches. Two of the patches are saturated stripe and checker patterns. On these the six-tap sums overshoot 255 and undershoot 0, so a design that clips late or shifts the wrong way shows wrapped values. They also catch a design that computes the centre sample from clipped intermediates: it drifts by a few codes at the j, f, i, k and q positions. Random FIFO stalls catch a design that advances its index or drops a write while full, because that misaligns the raster order. A start and a patch write issued mid-block expose a design that re-latches either one.

// File: rtl/qpel_luma_interp.sv
module qpel_luma_interp #(
  parameter int PW = 8,
  parameter int WN = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_we,
  input  logic [3:0]       win_row,
  input  logic [WN*PW-1:0] win_data,
  input  logic             start,
  input  logic [1:0]       frac_x,
  input  logic [1:0]       frac_y,
  input  logic             fifo_full,
  output logic             busy,
  output logic             out_wr,
  output logic [PW-1:0]    out_pix
);
  localparam int PMAX = (1 << PW) - 1;

  logic [PW-1:0] win [WN][WN];
  logic [3:0] idx;
  logic [1:0] fx_q, fy_q;
  logic [3:0] rr, cc;

  always_ff @(posedge clk)
    if (win_we && !busy && win_row < 4'(WN))
      for (int c = 0; c < WN; c++) win[win_row][c] <= win_data[c*PW +: PW];

  always_ff @(posedge clk)
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      fx_q <= '0;
      fy_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
        fx_q <= frac_x;
        fy_q <= frac_y;
      end
    end else if (out_wr) begin
      idx <= idx + 4'd1;
      if (idx == 4'd15) busy <= 1'b0;
    end

  assign out_wr = busy && !fifo_full;
  assign rr = {2'b00, idx[3:2]} + 4'd2;
  assign cc = {2'b00, idx[1:0]} + 4'd2;

  function automatic int px(logic [3:0] r, logic [3:0] c);
    return int'(win[r][c]);
  endfunction

  function automatic int fir(int e0, int e1, int e2, int e3, int e4, int e5);
    return e0 - 5*e1 + 20*e2 + 20*e3 - 5*e4 + e5;
  endfunction

  function automatic int hsum(logic [3:0] r, logic [3:0] c);
    return fir(px(r, c-4'd2), px(r, c-4'd1), px(r, c), px(r, c+4'd1), px(r, c+4'd2), px(r, c+4'd3));
  endfunction

  function automatic int vsum(logic [3:0] r, logic [3:0] c);
    return fir(px(r-4'd2, c), px(r-4'd1, c), px(r, c), px(r+4'd1, c), px(r+4'd2, c), px(r+4'd3, c));
  endfunction

  function automatic int clip(int v);
    return (v < 0) ? 0 : (v > PMAX) ? PMAX : v;
  endfunction

  function automatic logic [PW-1:0] avg(int a, int b);
    return PW'((a + b + 1) >>> 1);
  endfunction

  int g, gr, gd, hb, hs, vh, vm, cj;

  always_comb begin
    g  = px(rr, cc);
    gr = px(rr, cc + 4'd1);
    gd = px(rr + 4'd1, cc);
    hb = clip((hsum(rr, cc) + 16) >>> 5);
    hs = clip((hsum(rr + 4'd1, cc) + 16) >>> 5);
    vh = clip((vsum(rr, cc) + 16) >>> 5);
    vm = clip((vsum(rr, cc + 4'd1) + 16) >>> 5);
    cj = clip((fir(vsum(rr, cc-4'd2), vsum(rr, cc-4'd1), vsum(rr, cc),
                   vsum(rr, cc+4'd1), vsum(rr, cc+4'd2), vsum(rr, cc+4'd3)) + 512) >>> 10);
    case ({fy_q, fx_q})
      4'b00_00: out_pix = PW'(g);
      4'b00_01: out_pix = avg(g, hb);
      4'b00_10: out_pix = PW'(hb);
      4'b00_11: out_pix = avg(hb, gr);
      4'b01_00: out_pix = avg(g, vh);
      4'b01_01: out_pix = avg(hb, vh);
      4'b01_10: out_pix = avg(hb, cj);
      4'b01_11: out_pix = avg(hb, vm);
      4'b10_00: out_pix = PW'(vh);
      4'b10_01: out_pix = avg(vh, cj);
      4'b10_10: out_pix = PW'(cj);
      4'b10_11: out_pix = avg(cj, vm);
      4'b11_00: out_pix = avg(vh, gd);
      4'b11_01: out_pix = avg(vh, hs);
      4'b11_10: out_pix = avg(cj, hs);
      default:  out_pix = avg(vm, hs);
    endcase
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy && idx == 4'd0);
  p_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr && idx != 4'd15 |=> busy && idx == $past(idx) + 4'd1);
  p_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr && idx == 4'd15 |=> !busy);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && fifo_full |=> busy && $stable(idx) && $stable(out_pix));
  p_frac_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(fx_q) && $stable(fy_q));
endmodule

// File: tb/sim_qpel_luma_interp.sv
module sim_qpel_luma_interp;
  logic clk = 1'b0, rst_n = 1'b0;
  logic win_we = 1'b0, start = 1'b0, fifo_full = 1'b0;
  logic [3:0] win_row = '0;
  logic [71:0] win_data = '0;
  logic [1:0] frac_x = '0, frac_y = '0;
  logic busy, out_wr;
  logic [7:0] out_pix;

  qpel_luma_interp u0 (.clk, .rst_n, .win_we, .win_row, .win_data, .start,
    .frac_x, .frac_y, .fifo_full, .busy, .out_wr, .out_pix);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int w [9][9];
  int got [32];
  int ngot = 0, stall_bad = 0, stall_seen = 0;
  bit stall_en = 0;
  int unsigned lfsr = 32'hACE1;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr = lfsr * 1103515245 + 12345;
    fifo_full <= stall_en && lfsr[17];
  end

  always @(negedge clk) begin
    if (fifo_full && busy) stall_seen++;
    if (fifo_full && out_wr) stall_bad++;
    if (out_wr && ngot < 32) begin got[ngot] = out_pix; ngot++; end
  end

  function automatic int f6(int a, int b, int c, int d, int e, int f);
    return a + f - 5*(b + e) + 20*(c + d);
  endfunction
  function automatic int sat(int v); return v < 0 ? 0 : (v > 255 ? 255 : v); endfunction
  function automatic int hh(int r, int c); return f6(w[r][c-2], w[r][c-1], w[r][c], w[r][c+1], w[r][c+2], w[r][c+3]); endfunction
  function automatic int vv(int r, int c); return f6(w[r-2][c], w[r-1][c], w[r][c], w[r+1][c], w[r+2][c], w[r+3][c]); endfunction

  function automatic int model(int x, int y, int fx, int fy);
    int r = y + 2, c = x + 2;
    int pos [3][3];
    int full_r, full_d, b2, m2;
    pos[0][0] = w[r][c];
    pos[0][2] = sat((hh(r, c) + 16) / 32 + ((hh(r, c) + 16) < 0 ? -1 : 0) * 0);
    pos[0][2] = sat((hh(r, c) + 16) >>> 5);
    pos[2][0] = sat((vv(r, c) + 16) >>> 5);
    pos[2][2] = sat((f6(vv(r,c-2), vv(r,c-1), vv(r,c), vv(r,c+1), vv(r,c+2), vv(r,c+3)) + 512) >>> 10);
    full_r = w[r][c+1];
    full_d = w[r+1][c];
    b2 = sat((hh(r+1, c) + 16) >>> 5);
    m2 = sat((vv(r, c+1) + 16) >>> 5);
    if (fx % 2 == 0 && fy % 2 == 0) return pos[fy][fx];
    if (fx % 2 == 1 && fy % 2 == 1)
      return ((fy == 1 ? pos[0][2] : b2) + (fx == 1 ? pos[2][0] : m2) + 1) >> 1;
    if (fy == 0) return (pos[0][2] + (fx == 1 ? pos[0][0] : full_r) + 1) >> 1;
    if (fx == 0) return (pos[2][0] + (fy == 1 ? pos[0][0] : full_d) + 1) >> 1;
    if (fx == 2) return (pos[2][2] + (fy == 1 ? pos[0][2] : b2) + 1) >> 1;
    return (pos[2][2] + (fx == 1 ? pos[2][0] : m2) + 1) >> 1;
  endfunction

  task automatic fill(int kind);
    for (int r = 0; r < 9; r++)
      for (int c = 0; c < 9; c++) begin
        lfsr = lfsr * 1103515245 + 12345;
        case (kind)
          1: w[r][c] = (c % 2) ? 255 : 0;
          2: w[r][c] = ((r + c) % 2) ? 0 : 255;
          3: w[r][c] = (r * 29 + c * 3) % 256;
          default: w[r][c] = int'(lfsr[23:16]);
        endcase
      end
  endtask

  task automatic load();
    for (int r = 0; r < 9; r++) begin
      @(posedge clk); #1;
      win_we = 1'b1; win_row = 4'(r);
      for (int c = 0; c < 9; c++) win_data[c*8 +: 8] = 8'(w[r][c]);
    end
    @(posedge clk); #1; win_we = 1'b0;
  endtask

  task automatic run(int fx, int fy, bit disturb, string req);
    ngot = 0;
    @(posedge clk); #1;
    start = 1'b1; frac_x = 2'(fx); frac_y = 2'(fy);
    @(posedge clk); #1; start = 1'b0;
    if (disturb) begin
      @(posedge clk); #1;
      start = 1'b1; frac_x = 2'(fx ^ 3); frac_y = 2'(fy ^ 1);
      win_we = 1'b1; win_row = 4'd4; win_data = '0;
      @(posedge clk); #1; start = 1'b0; win_we = 1'b0;
    end
    while (busy) @(posedge clk);
    @(negedge clk);
    chk("R2 write count", ngot, 16);
    for (int k = 0; k < 16 && k < ngot; k++)
      chk(req, got[k], model(k % 4, k / 4, fx, fy));
  endtask

  function automatic string tag(int fx, int fy);
    if (fx == 0 && fy == 0) return "R3 full sample";
    if (fx == 2 && fy == 2) return "R5 centre half";
    if ((fx == 2 && fy == 0) || (fx == 0 && fy == 2)) return "R4 half sample";
    return "R6 quarter sample";
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 out_wr after reset", int'(out_wr), 0);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle without start", int'(busy | out_wr), 0);
    for (int kind = 0; kind < 5; kind++) begin
      stall_en = (kind >= 3);
      for (int f = 0; f < 16; f++) begin
        fill(kind);
        load();
        run(f % 4, f / 4, 1'b0, tag(f % 4, f / 4));
      end
    end
    chk("R7 write while full", stall_bad, 0);
    chk("R7 stalls exercised", int'(stall_seen > 0), 1);
    stall_en = 0;
    fill(0);
    load();
    run(1, 3, 1'b1, "R8 start or patch write while busy");
    fill(1);
    load();
    run(3, 2, 1'b1, "R8 start or patch write while busy");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule